// File: doc/BRIEF.md
# Descriptor-Driven Scatter-Gather DMA Engine

This block is a bus master that moves a disk command's data between system memory and a local sector buffer. It follows a list of eight-byte region descriptors held in memory. Each descriptor gives a start address, a byte count and a last-entry flag. The engine fetches one descriptor, moves its bytes in chunks, and then either fetches the next descriptor or finishes, depending on that flag. No chunk crosses a page boundary. When the memory port reports busy, the engine waits a fixed number of cycles and then tries again.

Control comes from the command layer. A one-cycle arm pulse, accepted only while the engine is idle, loads the direction and the command's byte budget and puts the engine into a start-pending state. A start pulse in that state latches the table base and begins the fetch. The engine ends with a one-cycle `done_o` when the table and the budget run out together, and with a one-cycle `err_o` in every other case: the budget is overrun, bytes are left over, or the transfer is aborted. A per-chunk valid/ready handshake on the buffer side carries the chunk length to the sector buffer. It comes before the memory write when data flows to memory, and after the memory read completes when data flows from memory.

Top module: `prd_dma_engine`

## Requirements
- R1: On start the table pointer is the programmed base with bits 1:0 forced to zero. Each descriptor fetch is a memory read of 8 bytes with `mem_desc_o` high, and each later fetch uses the previous fetch address plus 8.
- R2: A fetched word is decoded as address = bits 31:0, byte count = bits 47:32, last-entry flag = bit 63. A descriptor with a count of zero moves no data.
- R3: Every data chunk is min(bytes left in the descriptor, bytes from the current address up to the next 4096-byte page boundary). Chunks of one descriptor are contiguous and together cover its count exactly.
- R4: No request is issued while `mem_busy_i` is high. When busy is seen at a request point, the engine retries BACKOFF_CYCLES+1 cycles later, so the request points of a start are k = 1, B+2, 2B+3, ... cycles after the start edge.
- R5: With `to_mem_i`=1 (disk read) every data request is a memory write (`mem_we_o`=1), and the buffer handshake for a chunk comes before its request. With `to_mem_i`=0 every data request is a memory read, and the buffer handshake comes after its completion.
- R6: After a descriptor whose last-entry flag is set, the engine returns to idle. It pulses `done_o` if the remaining budget is zero and `err_o` otherwise.
- R7: A chunk larger than the remaining budget is never requested. The engine pulses `err_o` and returns to idle instead.
- R8: `start_i` is acted on only in the start-pending state entered by `arm_i`. A start while idle produces no request and no end pulse.
- R9: `abort_i` while the engine is not idle returns it to idle and pulses `err_o` on the next cycle, with no further requests.
- R10: During and right after reset, `mem_req_o`, `buf_valid_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Enter start-pending state, latch direction and budget |
| to_mem_i | input | 1 | 1: data flows buffer to memory; 0: memory to buffer |
| budget_i | input | BUDGET_W | Byte budget of the command |
| start_i | input | 1 | Begin walking the table |
| table_base_i | input | 32 | Descriptor table base address |
| abort_i | input | 1 | Cancel the transfer |
| mem_req_o | output | 1 | Memory request, one cycle per request |
| mem_desc_o | output | 1 | Request is a descriptor fetch |
| mem_we_o | output | 1 | Request writes memory |
| mem_addr_o | output | 32 | Request address |
| mem_len_o | output | LEN_W | Request length in bytes |
| mem_busy_i | input | 1 | Memory port cannot take a request |
| mem_ack_i | input | 1 | Current request has completed |
| mem_rdata_i | input | 64 | Descriptor word returned with the fetch completion |
| buf_valid_o | output | 1 | Chunk handshake toward the sector buffer |
| buf_len_o | output | LEN_W | Chunk length in bytes |
| buf_ready_i | input | 1 | Sector buffer accepts the chunk |
| done_o | output | 1 | Transfer finished cleanly (one cycle) |
| err_o | output | 1 | Transfer ended in error (one cycle) |

## Verification
A request appears in the same cycle the engine reaches a request point with busy low. The completion is consumed in a later cycle, and `done_o`/`err_o` rise one cycle after the deciding state. The bench drives inputs just after the falling edge and samples 3 ns later, so every handshake is logged in the cycle whose rising edge captures it, together with that cycle's index. The retry check compares the index of the first request with the start cycle plus 2·B+3 under a forced busy window. The other checks compare the full ordered log of fetches, data requests and buffer handshakes with a list built by a bench model.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_REQ,
    ST_BACKOFF,
    ST_ACK,
    ST_CHUNK,
    ST_BUF
  } prd_state_e;

  // 64-bit descriptor as returned by the fetch
  typedef struct packed {
    logic        last;
    logic [14:0] rsvd;
    logic [15:0] count;
    logic [31:0] addr;
  } prd_desc_t;

endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc #(
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int LEN_W     = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [LEN_W-1:0] len_o
);

  logic [LEN_W-1:0] cap;
  logic [LEN_W-1:0] room;

  always_comb begin
    cap   = (remain_i >= CNT_W'(PAGE_BYTES)) ? LEN_W'(PAGE_BYTES) : LEN_W'(remain_i);
    room  = LEN_W'(PAGE_BYTES) - LEN_W'(off_i);
    len_o = (cap >= room) ? room : cap;
  end

endmodule

// File: rtl/prd_backoff_timer.sv
module prd_backoff_timer #(
  parameter int CYCLES = 4,
  localparam int CW    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYCLES - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= CYCLES - 1); // R4

endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int PAGE_BYTES     = 4096,
  parameter int BACKOFF_CYCLES = 4,
  parameter int BUDGET_W       = 18,
  localparam int CNT_W         = 16,
  localparam int OFF_W         = $clog2(PAGE_BYTES),
  localparam int LEN_W         = OFF_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                to_mem_i,
  input  logic [BUDGET_W-1:0] budget_i,
  input  logic                start_i,
  input  logic [31:0]         table_base_i,
  input  logic                abort_i,
  output logic                mem_req_o,
  output logic                mem_desc_o,
  output logic                mem_we_o,
  output logic [31:0]         mem_addr_o,
  output logic [LEN_W-1:0]    mem_len_o,
  input  logic                mem_busy_i,
  input  logic                mem_ack_i,
  input  logic [63:0]         mem_rdata_i,
  output logic                buf_valid_o,
  output logic [LEN_W-1:0]    buf_len_o,
  input  logic                buf_ready_i,
  output logic                done_o,
  output logic                err_o
);

  prd_state_e          state_q;
  logic                to_mem_q, fetch_q, last_q, done_q, err_q;
  logic [BUDGET_W-1:0] budget_q;
  logic [31:0]         ptr_q, cur_addr_q;
  logic [CNT_W-1:0]    rem_q;
  logic [LEN_W-1:0]    len_q, chunk_len;
  logic                backoff_done;
  prd_desc_t           desc;

  assign desc = prd_desc_t'(mem_rdata_i);

  prd_chunk_calc #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_chunk (
    .off_i    (cur_addr_q[OFF_W-1:0]),
    .remain_i (rem_q),
    .len_o    (chunk_len)
  );

  prd_backoff_timer #(.CYCLES(BACKOFF_CYCLES)) u_backoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_REQ && mem_busy_i),
    .expired_o (backoff_done)
  );

  assign mem_req_o   = (state_q == ST_REQ) && !mem_busy_i;
  assign mem_desc_o  = mem_req_o && fetch_q;
  assign mem_we_o    = mem_req_o && !fetch_q && to_mem_q;
  assign mem_addr_o  = fetch_q ? ptr_q : cur_addr_q;
  assign mem_len_o   = fetch_q ? LEN_W'(DESC_BYTES) : len_q;
  assign buf_valid_o = (state_q == ST_BUF);
  assign buf_len_o   = len_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      to_mem_q   <= 1'b0;
      fetch_q    <= 1'b0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      budget_q   <= '0;
      ptr_q      <= '0;
      cur_addr_q <= '0;
      rem_q      <= '0;
      len_q      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (abort_i && state_q != ST_IDLE) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (arm_i) begin
            to_mem_q <= to_mem_i;
            budget_q <= budget_i;
            state_q  <= ST_ARMED;
          end
          ST_ARMED: if (start_i) begin
            ptr_q   <= table_base_i & ~32'h3;
            fetch_q <= 1'b1;
            state_q <= ST_REQ;
          end
          ST_REQ:     state_q <= mem_busy_i ? ST_BACKOFF : ST_ACK;
          ST_BACKOFF: if (backoff_done) state_q <= ST_REQ;
          ST_ACK: if (mem_ack_i) begin
            if (fetch_q) begin
              cur_addr_q <= desc.addr;
              rem_q      <= desc.count;
              last_q     <= desc.last;
              ptr_q      <= ptr_q + 32'(DESC_BYTES);
              state_q    <= ST_CHUNK;
            end else begin
              cur_addr_q <= cur_addr_q + 32'(len_q);
              rem_q      <= rem_q - CNT_W'(len_q);
              budget_q   <= budget_q - BUDGET_W'(len_q);
              state_q    <= to_mem_q ? ST_CHUNK : ST_BUF;
            end
          end
          ST_CHUNK: begin
            if (rem_q == '0) begin
              if (last_q) begin
                done_q  <= (budget_q == '0);
                err_q   <= (budget_q != '0);
                state_q <= ST_IDLE;
              end else begin
                fetch_q <= 1'b1;
                state_q <= ST_REQ;
              end
            end else if (BUDGET_W'(chunk_len) > budget_q) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              len_q   <= chunk_len;
              fetch_q <= 1'b0;
              state_q <= to_mem_q ? ST_BUF : ST_REQ;
            end
          end
          ST_BUF: if (buf_ready_i) state_q <= to_mem_q ? ST_REQ : ST_CHUNK;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_FETCH_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_desc_o |-> (mem_addr_o[1:0] == 2'b00 && 32'(mem_len_o) == DESC_BYTES)); // R1

  AST_DESC_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && fetch_q && mem_ack_i) |-> desc.rsvd == '0); // R2

  AST_PAGE_CHUNK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_desc_o) |->
      (mem_len_o != '0 && 32'(mem_addr_o[OFF_W-1:0]) + 32'(mem_len_o) <= PAGE_BYTES)); // R3

  AST_BUDGET_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_ARMED) |=> budget_q <= $past(budget_q)); // R7

  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (state_q == ST_IDLE && !mem_req_o)); // R6

  AST_BUSY_BACKOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && mem_busy_i) |=> !mem_req_o); // R4

endmodule

// File: tb/tb_prd_dma_engine.sv
`timescale 1ns/1ps
module tb_prd_dma_engine;
  localparam int PAGE = 4096;
  localparam int B    = 4;
  localparam int BW   = 18;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic arm_i = 0, to_mem_i = 0, start_i = 0, abort_i = 0;
  logic [BW-1:0] budget_i = '0;
  logic [31:0] table_base_i = '0;
  logic mem_req_o, mem_desc_o, mem_we_o, buf_valid_o, done_o, err_o;
  logic [31:0] mem_addr_o;
  logic [12:0] mem_len_o, buf_len_o;
  logic mem_busy_i = 0, mem_ack_i = 0, buf_ready_i = 0;
  logic [63:0] mem_rdata_i = '0;

  always #4 clk = ~clk;

  prd_dma_engine #(.PAGE_BYTES(PAGE), .BACKOFF_CYCLES(B), .BUDGET_W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .to_mem_i(to_mem_i), .budget_i(budget_i),
    .start_i(start_i), .table_base_i(table_base_i), .abort_i(abort_i),
    .mem_req_o(mem_req_o), .mem_desc_o(mem_desc_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .mem_busy_i(mem_busy_i),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .buf_valid_o(buf_valid_o),
    .buf_len_o(buf_len_o), .buf_ready_i(buf_ready_i), .done_o(done_o), .err_o(err_o));

  int checks = 0, errors = 0, cyc = 0;

  // event log: kind 0 fetch, 1 data, 2 buffer handshake
  int ev_kind[256], ev_len[256], ev_cyc[256];
  logic [31:0] ev_addr[256];
  bit ev_we[256];
  int ev_n = 0;
  int ex_kind[256], ex_len[256];
  logic [31:0] ex_addr[256];
  bit ex_we[256];
  int ex_n = 0;
  bit ex_done;

  logic [31:0] tbl_addr[8];
  int tbl_cnt[8];
  bit tbl_last[8];
  int tbl_n = 0;
  logic [31:0] tbl_base = '0;

  bit rand_busy = 0, forced = 0;
  int busy_lo = 0, busy_hi = 0;
  int done_seen = 0, err_seen = 0;
  bit pend = 0;
  int lat = 0;
  logic [63:0] pend_data = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic log_ev(input int k, input logic [31:0] a, input int l, input bit w);
    if (ev_n < 256) begin
      ev_kind[ev_n] = k; ev_addr[ev_n] = a; ev_len[ev_n] = l; ev_we[ev_n] = w;
      ev_cyc[ev_n] = cyc;
      ev_n++;
    end
  endtask

  task automatic push_ex(input int k, input logic [31:0] a, input int l, input bit w);
    if (ex_n < 256) begin
      ex_kind[ex_n] = k; ex_addr[ex_n] = a; ex_len[ex_n] = l; ex_we[ex_n] = w;
      ex_n++;
    end
  endtask

  function automatic logic [63:0] desc_word(input logic [31:0] a);
    int idx;
    idx = int'((a - tbl_base) >> 3);
    if (idx >= 0 && idx < tbl_n)
      return {tbl_last[idx], 15'd0, 16'(tbl_cnt[idx]), tbl_addr[idx]};
    return 64'h8000_0000_0000_0000;
  endfunction

  // reference walk of the table
  task automatic build_expected(input bit dir, input int budget);
    logic [31:0] p, a;
    int b, r, l, room;
    ex_n = 0; ex_done = 0; p = tbl_base; b = budget;
    for (int i = 0; i < tbl_n; i++) begin
      push_ex(0, p, 8, 0);
      p = p + 32'd8;
      a = tbl_addr[i]; r = tbl_cnt[i];
      while (r > 0) begin
        room = PAGE - int'(a % PAGE);
        l = (r < room) ? r : room;
        if (l > b) begin ex_done = 0; return; end
        if (dir) begin push_ex(2, 0, l, 0); push_ex(1, a, l, 1); end
        else     begin push_ex(1, a, l, 0); push_ex(2, 0, l, 0); end
        a = a + 32'(l); r -= l; b -= l;
      end
      if (tbl_last[i]) begin ex_done = (b == 0); return; end
    end
  endtask

  // memory and buffer responder
  initial begin
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      cyc++;
      mem_ack_i = 0;
      if (pend) begin
        if (lat == 0) begin mem_ack_i = 1; mem_rdata_i = pend_data; pend = 0; end
        else lat--;
      end
      if (forced) mem_busy_i = (cyc >= busy_lo && cyc <= busy_hi);
      else        mem_busy_i = rand_busy && ($urandom % 4 == 0);
      buf_ready_i = ($urandom % 3 != 0);
      #3;
      if (mem_req_o) begin
        log_ev(mem_desc_o ? 0 : 1, mem_addr_o, int'(mem_len_o), mem_we_o);
        pend = 1; lat = $urandom % 3;
        pend_data = mem_desc_o ? desc_word(mem_addr_o) : 64'd0;
      end
      if (buf_valid_o && buf_ready_i) log_ev(2, 0, int'(buf_len_o), 0);
      if (done_o) done_seen++;
      if (err_o)  err_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int c0 = 0;

  task automatic run_transfer(input bit dir, input int budget, input logic [31:0] base_raw,
                              input bit force_busy, input string tag);
    string t;
    tbl_base = base_raw & ~32'h3;
    build_expected(dir, budget);
    ev_n = 0; done_seen = 0; err_seen = 0;
    @(negedge clk); #1;
    arm_i = 1; to_mem_i = dir; budget_i = BW'(budget);
    @(negedge clk); #1;
    arm_i = 0; start_i = 1; table_base_i = base_raw; c0 = cyc;
    if (force_busy) begin forced = 1; busy_lo = c0 + 1; busy_hi = c0 + B + 2; end
    @(negedge clk); #1;
    start_i = 0;
    for (int w = 0; w < 20000 && done_seen == 0 && err_seen == 0; w++) @(negedge clk);
    repeat (6) @(negedge clk);
    forced = 0;
    check(ev_n == ex_n, tag, "event count", ev_n, ex_n);
    for (int i = 0; i < ev_n && i < ex_n; i++) begin
      t = (ex_kind[i] == 0) ? "R1" : (ex_kind[i] == 1) ? "R3" : "R5";
      check(ev_kind[i] == ex_kind[i], "R5", "event order kind", ev_kind[i], ex_kind[i]);
      if (ex_kind[i] != 2)
        check(ev_addr[i] == ex_addr[i], t, "address", ev_addr[i], ex_addr[i]);
      check(ev_len[i] == ex_len[i], t, "length", ev_len[i], ex_len[i]);
      check(ev_we[i] == ex_we[i], "R5", "write enable", ev_we[i], ex_we[i]);
    end
    check(done_seen == int'(ex_done) && err_seen == int'(!ex_done), "R6",
          "end pulse done/err", done_seen * 10 + err_seen, ex_done ? 10 : 1);
  endtask

  task automatic set_one(input int i, input logic [31:0] a, input int c, input bit l);
    tbl_addr[i] = a; tbl_cnt[i] = c; tbl_last[i] = l;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #3;
    check(!mem_req_o && !buf_valid_o && !done_o && !err_o, "R10", "outputs in reset",
          {mem_req_o, buf_valid_o, done_o, err_o}, 0);
    @(negedge clk); #1; rst_ni = 1;
    @(negedge clk); #3;
    check(!mem_req_o && !buf_valid_o && !done_o && !err_o, "R10", "outputs after reset",
          {mem_req_o, buf_valid_o, done_o, err_o}, 0);

    // R8: start without arm
    ev_n = 0; done_seen = 0; err_seen = 0;
    @(negedge clk); #1; start_i = 1; table_base_i = 32'h100;
    @(negedge clk); #1; start_i = 0;
    repeat (20) @(negedge clk);
    check(ev_n == 0 && done_seen == 0 && err_seen == 0, "R8", "start while idle",
          ev_n + done_seen + err_seen, 0);

    // R3 R2: unaligned region spanning pages, empty descriptor, read direction
    tbl_n = 3;
    set_one(0, 32'h0002_0FF0, 4096 + 32, 0);
    set_one(1, 32'h0003_0000, 0, 0);
    set_one(2, 32'h0004_0FFE, 6, 1);
    run_transfer(0, 4096 + 38, 32'h0000_8003, 0, "R2");

    // R4: forced busy window, first request at 2B+3
    tbl_n = 1; set_one(0, 32'h0005_0000, 64, 1);
    run_transfer(1, 64, 32'h0000_9000, 1, "R4");
    check(ev_n > 0 && ev_cyc[0] - c0 == 2 * B + 3, "R4", "first request cycle",
          ev_n > 0 ? ev_cyc[0] - c0 : -1, 2 * B + 3);

    // R7: chunk exceeds budget
    tbl_n = 1; set_one(0, 32'h0006_0000, 1024, 1);
    run_transfer(1, 512, 32'h0000_A000, 0, "R7");

    // R6: leftover budget at last entry
    tbl_n = 2; set_one(0, 32'h0007_0100, 256, 0); set_one(1, 32'h0007_2000, 256, 1);
    run_transfer(0, 1024, 32'h0000_B002, 0, "R6");

    // R9: abort during backoff
    tbl_n = 1; set_one(0, 32'h0008_0000, 512, 1);
    ev_n = 0; done_seen = 0; err_seen = 0;
    @(negedge clk); #1; arm_i = 1; to_mem_i = 1; budget_i = BW'(512);
    @(negedge clk); #1; arm_i = 0; start_i = 1; table_base_i = 32'h0000_C000;
    forced = 1; busy_lo = cyc + 1; busy_hi = cyc + 100000;
    @(negedge clk); #1; start_i = 0;
    repeat (10) @(negedge clk);
    #1; abort_i = 1;
    @(negedge clk); #1; abort_i = 0;
    repeat (2) @(negedge clk);
    check(err_seen == 1 && done_seen == 0, "R9", "abort error pulse", err_seen, 1);
    forced = 0;
    repeat (10) @(negedge clk);
    check(ev_n == 0, "R9", "no request after abort", ev_n, 0);
    @(negedge clk); #1; start_i = 1;
    @(negedge clk); #1; start_i = 0;
    repeat (15) @(negedge clk);
    check(ev_n == 0 && err_seen == 1, "R9", "idle after abort", ev_n, 0);

    // random walks with busy back-pressure
    rand_busy = 1;
    for (int n = 0; n < 30; n++) begin
      int sum, bud;
      tbl_n = 1 + $urandom % 4; sum = 0;
      for (int i = 0; i < tbl_n; i++) begin
        int off, cnt;
        off = ($urandom % 3 == 0) ? PAGE - 2 * int'($urandom % 8) - 2 : int'($urandom % PAGE);
        cnt = ($urandom % 8 == 0) ? 0 : int'($urandom % 9000);
        set_one(i, 32'h0010_0000 + 32'(i) * 32'h0001_0000 + 32'(off), cnt, i == tbl_n - 1);
        sum += cnt;
      end
      bud = sum;
      if ($urandom % 5 == 0) bud = sum + 64;
      else if ($urandom % 5 == 0 && sum > 100) bud = sum - 100;
      run_transfer($urandom % 2, bud, 32'h0000_8000 + 32'($urandom % 64) * 16 + 32'($urandom % 4),
                   0, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule